// File: doc/BRIEF.md
# Serial Port Hold Suspend Controller

This block sits between the pins of a serial peripheral port and the protocol engine behind it. It provides the pause function driven by an active-low hold input. While the device is selected, the engine can be frozen in the middle of a transfer and later resume from the same bit position. The port's serial clock, hold and select pins are oversampled in the system clock domain through a configurable synchronizer chain. The block turns the serial clock into one-cycle rising and falling strobes for the engine. It also produces a clock enable that stops the engine's bit counter and shift registers, and a gated output enable for the serial data output.

The block changes between running and paused only at points where the serial clock is low. If hold drops while the clock is low, the engine freezes at once. If hold drops while the clock is high, the request is armed and takes effect at the next falling clock edge. That falling edge is still delivered to the engine, so it can finish its half-cycle. A release is accepted only when hold is high and the clock is low. While paused, clock edges are swallowed, so activity on the clock and data lines has no effect on the engine. The data output enable is removed combinationally as soon as the raw hold pin goes low. Deselection returns the controller to the running state, in step with the engine's own reset on deselect.

Top module: `hold_suspend`

## Requirements
- R1: During reset (active-low `rstN`), `sckRise`, `sckFall`, `engEn`, `soOe` and `held` are all 0.
- R2: Each pin is seen after SYNC_STAGES system clock flops (default 2). When selected and not held, a 0-to-1 change of the synchronized serial clock gives exactly one `sckRise` pulse, and a 1-to-0 change gives exactly one `sckFall` pulse.
- R3: When selected and running, synchronized hold low with the synchronized clock low sets `held` on the next system clock edge.
- R4: When hold goes low while the synchronized clock is high, `held` stays 0 and strobes keep flowing until the clock is low. The falling edge that ends this wait is still delivered as `sckFall`.
- R5: When held, `held` clears only when synchronized hold is high and the synchronized clock is low. Hold returning high while the clock is high keeps `held` at 1.
- R6: While `held` is 1, `sckRise`, `sckFall` and `engEn` are all 0, whatever the clock and data lines do.
- R7: `soOe` is 0 in the same cycle as the raw `holdNPin` is 0, with no flop in between.
- R8: `soOe` equals `soReq` whenever the device is selected, not held, and `holdNPin` is 1.
- R9: While the synchronized select is high (deselected), `engEn`, the strobes and `soOe` are 0, and `held` clears on the next edge.
- R10: If hold returns high before an armed entry reaches a clock-low point, no pause takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the port |
| rstN | input | 1 | Asynchronous active-low reset |
| sckPin | input | 1 | Serial clock pin |
| holdNPin | input | 1 | Active-low hold pin |
| csNPin | input | 1 | Active-low select pin |
| soReq | input | 1 | Engine asks to drive the serial data output |
| sckRise | output | 1 | Gated rising-edge strobe for the engine |
| sckFall | output | 1 | Gated falling-edge strobe for the engine |
| engEn | output | 1 | Clock enable for the engine's counter and shifters |
| soOe | output | 1 | Output enable for the serial data output |
| held | output | 1 | Engine is paused |

## Verification
Directed sequences cover hold dropping with the clock low and with the clock high. They also cover hold rising with the clock high and with the clock low, an armed hold cancelled before the clock falls, and deselection during a pause. Together these separate immediate entry, deferred entry, deferred release and cancellation, which a design that ignores the clock level would mix up. Constrained random traffic toggles the clock often and hold and select rarely, with random output requests. Each cycle is compared with a bench model of the requirements, which checks the strobe gating and the combinational output-enable cut across many edge and hold alignments.

// File: rtl/hold_sus_pkg.sv
package hold_sus_pkg;

  typedef enum logic [1:0] {
    HS_RUN   = 2'd0,
    HS_ARMED = 2'd1,
    HS_HELD  = 2'd2
  } holdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic gateOpen;  // engine may advance
    logic soAllow;   // output may be driven
  } holdCtl_t;

endpackage

// File: rtl/hold_sus_dp.sv
module hold_sus_dp
  import hold_sus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sckPin,
  input  logic     holdNPin,
  input  logic     csNPin,
  input  logic     soReq,
  input  holdCtl_t ctl,
  output logic     sckSync,
  output logic     holdSync,
  output logic     selSync,
  output logic     sckRise,
  output logic     sckFall,
  output logic     engEn,
  output logic     soOe
);

  localparam int NSIG = 3;
  // reset view of pins: deselected, hold released, clock low
  localparam logic [NSIG-1:0] RST_V = 3'b110;

  logic [NSIG-1:0] rawV;
  logic [NSIG-1:0] syncV;
  logic            sckQ;

  assign rawV = {csNPin, holdNPin, sckPin};

  if (SYNC_STAGES == 0) begin : g_nosync
    assign syncV = rawV;
  end else begin : g_sync
    logic [NSIG-1:0] chain [SYNC_STAGES];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= RST_V;
      end else begin
        chain[0] <= rawV;
        for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      end
    end
    assign syncV = chain[SYNC_STAGES-1];
  end

  assign sckSync  = syncV[0];
  assign holdSync = syncV[1];
  assign selSync  = ~syncV[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckQ <= 1'b0;
    else       sckQ <= sckSync;
  end

  assign sckRise = sckSync & ~sckQ & ctl.gateOpen;
  assign sckFall = ~sckSync & sckQ & ctl.gateOpen;
  assign engEn   = ctl.gateOpen;
  // raw pin gates the enable with no flop: tri-state is immediate
  assign soOe    = soReq & holdNPin & ctl.soAllow;

  // R7: raw hold low forces the output enable off
  a_r7_so_cut: assert property (@(posedge clk) disable iff (!rstN)
    !holdNPin |-> !soOe);

  // R2: a rise and a fall strobe never coincide
  a_r2_one_edge: assert property (@(posedge clk) disable iff (!rstN)
    !(sckRise && sckFall));

endmodule

// File: rtl/hold_sus_ctl.sv
module hold_sus_ctl
  import hold_sus_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sckSync,
  input  logic     holdSync,
  input  logic     selSync,
  output holdCtl_t ctl,
  output logic     held
);

  holdState_e state, stateNxt;

  always_comb begin
    stateNxt = state;
    if (!selSync) begin
      stateNxt = HS_RUN;
    end else begin
      unique case (state)
        HS_RUN:   if (!holdSync) stateNxt = sckSync ? HS_ARMED : HS_HELD;
        HS_ARMED: if (holdSync) stateNxt = HS_RUN;
                  else if (!sckSync) stateNxt = HS_HELD;
        HS_HELD:  if (holdSync && !sckSync) stateNxt = HS_RUN;
        default:  stateNxt = HS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= HS_RUN;
    else       state <= stateNxt;
  end

  assign held         = (state == HS_HELD);
  assign ctl.gateOpen = selSync & ~held;
  assign ctl.soAllow  = selSync & ~held;

  // R3: hold low at a clock-low point enters the pause
  a_r3_enter_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == HS_RUN && selSync && !holdSync && !sckSync) |=> held);

  // R4: hold low with the clock high does not pause yet
  a_r4_defer_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!held && selSync && sckSync) |=> !held);

  // R5: the pause persists unless hold is high at a clock-low point
  a_r5_release_low: assert property (@(posedge clk) disable iff (!rstN)
    (held && selSync && !(holdSync && !sckSync)) |=> held);

  // R9: deselection clears the pause
  a_r9_deselect: assert property (@(posedge clk) disable iff (!rstN)
    !selSync |=> !held);

  // R10: a hold released while armed cancels the entry
  a_r10_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (state == HS_ARMED && holdSync) |=> !held);

endmodule

// File: rtl/hold_suspend.sv
module hold_suspend
  import hold_sus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckPin,
  input  logic holdNPin,
  input  logic csNPin,
  input  logic soReq,
  output logic sckRise,
  output logic sckFall,
  output logic engEn,
  output logic soOe,
  output logic held
);

  holdCtl_t ctl;
  logic     sckSync, holdSync, selSync;

  hold_sus_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sckPin   (sckPin),
    .holdNPin (holdNPin),
    .csNPin   (csNPin),
    .soReq    (soReq),
    .ctl      (ctl),
    .sckSync  (sckSync),
    .holdSync (holdSync),
    .selSync  (selSync),
    .sckRise  (sckRise),
    .sckFall  (sckFall),
    .engEn    (engEn),
    .soOe     (soOe)
  );

  hold_sus_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .sckSync  (sckSync),
    .holdSync (holdSync),
    .selSync  (selSync),
    .ctl      (ctl),
    .held     (held)
  );

  // R6: the engine is frozen while paused
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rstN)
    held |-> (!sckRise && !sckFall && !engEn));

endmodule

// File: tb/sim_hold_suspend.sv
module sim_hold_suspend;

  localparam int S = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckPin = 1'b0, holdNPin = 1'b1, csNPin = 1'b1, soReq = 1'b0;
  logic sckRise, sckFall, engEn, soOe, held;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  hold_suspend #(.SYNC_STAGES(S)) u0 (
    .clk(clk), .rstN(rstN), .sckPin(sckPin), .holdNPin(holdNPin),
    .csNPin(csNPin), .soReq(soReq), .sckRise(sckRise), .sckFall(sckFall),
    .engEn(engEn), .soOe(soOe), .held(held)
  );

  // bench model: pins seen after S flops; 0 run, 1 armed, 2 paused
  logic mSck [S];
  logic mHold [S];
  logic mCs [S];
  logic mSckQ;
  int   mState;

  function automatic logic modelGate();
    return !mCs[S-1] && (mState != 2);
  endfunction

  function automatic int nextState(int st, logic sel, logic h, logic s);
    if (!sel) return 0;
    case (st)
      0: return h ? 0 : (s ? 1 : 2);
      1: return h ? 0 : (s ? 1 : 2);
      default: return (h && !s) ? 0 : 2;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < S; i++) begin
      mSck[i] = 1'b0; mHold[i] = 1'b1; mCs[i] = 1'b1;
    end
    mSckQ = 1'b0;
    mState = 0;
  endtask

  task automatic modelClock();
    if (!rstN) begin
      modelReset();
    end else begin
      mState = nextState(mState, !mCs[S-1], mHold[S-1], mSck[S-1]);
      mSckQ = mSck[S-1];
      for (int i = S-1; i > 0; i--) begin
        mSck[i] = mSck[i-1]; mHold[i] = mHold[i-1]; mCs[i] = mCs[i-1];
      end
      mSck[0] = sckPin; mHold[0] = holdNPin; mCs[0] = csNPin;
    end
  endtask

  task automatic cmp(input logic act, input logic exp, input string tag, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic g;
    g = modelGate();
    cmp(sckRise, mSck[S-1] && !mSckQ && g, "R2/R6", "sckRise");
    cmp(sckFall, !mSck[S-1] && mSckQ && g, "R2/R4/R6", "sckFall");
    cmp(engEn, g, "R6/R9", "engEn");
    cmp(soOe, soReq && holdNPin && g, "R7/R8", "soOe");
    cmp(held, mState == 2, "R3/R5/R9/R10", "held");
  endtask

  // apply pins, let one clock edge pass, compare at the falling clk edge
  task automatic step(input logic s, input logic h, input logic c, input logic r);
    sckPin = s; holdNPin = h; csNPin = c; soReq = r;
    @(posedge clk);
    modelClock();
    @(negedge clk);
    compareAll();
  endtask

  task automatic hold4(input logic s, input logic h, input logic c, input logic r);
    for (int i = 0; i < 4; i++) step(s, h, c, r);
  endtask

  initial begin
    int unsigned seedVal;
    logic rs, rh, rc, rr;
    seedVal = $urandom(32'h1d5e_ed42);
    modelReset();
    // R1: reset state
    repeat (3) @(negedge clk);
    cmp(sckRise, 1'b0, "R1", "reset sckRise");
    cmp(sckFall, 1'b0, "R1", "reset sckFall");
    cmp(engEn, 1'b0, "R1", "reset engEn");
    cmp(soOe, 1'b0, "R1", "reset soOe");
    cmp(held, 1'b0, "R1", "reset held");
    rstN = 1'b1;

    // select, clock a few bits
    hold4(1'b0, 1'b1, 1'b0, 1'b1);
    cmp(engEn, 1'b1, "R8", "engEn after select");
    cmp(soOe, 1'b1, "R8", "soOe when selected");
    for (int i = 0; i < 3; i++) begin step(1'b1, 1'b1, 1'b0, 1'b1); step(1'b0, 1'b1, 1'b0, 1'b1); end

    // R3 and R7: hold drops with the clock low
    step(1'b0, 1'b0, 1'b0, 1'b1);
    cmp(soOe, 1'b0, "R7", "soOe same cycle as hold low");
    hold4(1'b0, 1'b0, 1'b0, 1'b1);
    cmp(held, 1'b1, "R3", "paused after low-clock hold");
    // R6: clock activity swallowed
    for (int i = 0; i < 4; i++) begin step(1'b1, 1'b0, 1'b0, 1'b1); step(1'b0, 1'b0, 1'b0, 1'b1); end
    cmp(engEn, 1'b0, "R6", "engine frozen");
    // R5: release with clock high is deferred
    hold4(1'b1, 1'b1, 1'b0, 1'b1);
    cmp(held, 1'b1, "R5", "release deferred while clock high");
    cmp(soOe, 1'b0, "R5", "output off while still paused");
    hold4(1'b0, 1'b1, 1'b0, 1'b1);
    cmp(held, 1'b0, "R5", "released at clock low");
    cmp(soOe, 1'b1, "R8", "output back after release");

    // R4: hold with the clock high waits for the fall
    hold4(1'b1, 1'b1, 1'b0, 1'b0);
    hold4(1'b1, 1'b0, 1'b0, 1'b0);
    cmp(held, 1'b0, "R4", "not paused while clock high");
    cmp(engEn, 1'b1, "R4", "engine running while armed");
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    cmp(sckFall, 1'b1, "R4", "entry falling edge delivered");
    step(1'b0, 1'b0, 1'b0, 1'b0);
    cmp(held, 1'b1, "R4", "paused after falling edge");

    // R9: deselect while paused
    hold4(1'b0, 1'b0, 1'b1, 1'b1);
    cmp(held, 1'b0, "R9", "deselect clears pause");
    cmp(engEn, 1'b0, "R9", "engine off when deselected");

    // R10: armed entry cancelled
    hold4(1'b1, 1'b1, 1'b0, 1'b1);
    hold4(1'b1, 1'b0, 1'b0, 1'b1);
    hold4(1'b1, 1'b1, 1'b0, 1'b1);
    hold4(1'b0, 1'b1, 1'b0, 1'b1);
    cmp(held, 1'b0, "R10", "cancelled hold never pauses");

    // constrained random traffic
    rs = 1'b0; rh = 1'b1; rc = 1'b0; rr = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(99) < 40) rs = ~rs;
      if ($urandom_range(99) < 6)  rh = ~rh;
      if ($urandom_range(99) < 2)  rc = ~rc;
      rr = $urandom_range(1);
      step(rs, rh, rc, rr);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule